// File: doc/BRIEF.md
# 64-bit Integer Add/Subtract Unit with Carry and Condition Flags

This block is the integer add and subtract datapath of a load/store processor core. It is purely combinational: the operands, a 16-bit signed immediate, the operation code and the incoming status bits are presented, and the result, a two-bit carry vector and a four-bit signed condition field are available in the same cycle. Write-enable outputs tell the surrounding pipeline whether the carry vector and the condition field should be committed.

Eight operations are supported: register add, subtract-from, add with incoming carry, add of carry plus minus one, add of carry alone, immediate add, shifted-immediate add and subtract-from-immediate. Every operation is reduced to one adder input pair and a carry-in. The adder is split at the word midpoint so that the carry out of the low 32 bits is reported next to the full-width carry. The condition field classifies the result as negative, positive or zero and carries the sticky summary-overflow bit along in its lowest position.

Top module: `int_addsub`

## Requirements
- R1: With op_i = 0 (register add), res_o equals a_i + b_i modulo 2^64.
- R2: With op_i = 1 (subtract-from), res_o equals (~a_i) + b_i + 1 modulo 2^64.
- R3: With op_i = 2 (extended add), res_o equals a_i + b_i + ca_i modulo 2^64.
- R4: With op_i = 3 (minus-one add), res_o equals a_i + ca_i + 0xFFFF_FFFF_FFFF_FFFF; with op_i = 4 (zero add), res_o equals a_i + ca_i; both modulo 2^64.
- R5: With op_i = 5 (immediate add) res_o equals A + sext(imm_i); with op_i = 6 (shifted-immediate add) res_o equals A + (sext(imm_i) << 16); A is zero when ra_is_r0_i = 1 and a_i otherwise.
- R6: With op_i = 7 (subtract-from-immediate), res_o equals (~a_i) + sext(imm_i) + 1 modulo 2^64.
- R7: carry_o[0] is the carry out of bit 63 of the sum that forms res_o, and carry_o[1] is the carry out of bit 31 of that same sum, carry-in included.
- R8: carry_we_o is 1 exactly when op_i is 2, 3, 4 or 7.
- R9: cond_o bit 3 is set when res_o[63] = 1, bit 2 when res_o is nonzero with bit 63 clear, bit 1 when res_o is zero, and bit 0 always equals so_i, for every operation.
- R10: cond_we_o equals rec_i for every operation.
- R11: ra_is_r0_i has no effect on res_o or carry_o for op_i values 0 to 4 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 64 | First operand (register A contents) |
| b_i | input | 64 | Second operand (register B contents) |
| imm_i | input | 16 | Signed immediate |
| op_i | input | 3 | Operation select, encodings 0 to 7 as in R1 to R6 |
| ra_is_r0_i | input | 1 | A register field names register zero |
| ca_i | input | 1 | Incoming carry bit |
| so_i | input | 1 | Incoming summary-overflow bit |
| rec_i | input | 1 | Record form, requests a condition update |
| res_o | output | 64 | Result |
| carry_o | output | 2 | Bit 0: carry out of bit 63; bit 1: carry out of bit 31 |
| carry_we_o | output | 1 | Carry vector is to be written |
| cond_o | output | 4 | Condition field: negative, positive, zero, summary overflow |
| cond_we_o | output | 1 | Condition field is to be written |

## Verification
The checker holds on every evaluation that the condition field has exactly one of its three sign bits set in agreement with the result, that its low bit mirrors the summary-overflow input, that both write enables follow the operation and record inputs, and that the register and extended add results match independent sums. The bench's scenarios are needed for the operations whose operand steering is less direct: the minus-one and zero adds under both carry values, the register-zero substitution for the immediate forms and its absence elsewhere, the sign handling of negative immediates, and the split carry, where the low-word and full-width carries disagree.

// File: rtl/int_addsub_pkg.sv
package int_addsub_pkg;

    localparam int AS_XLEN  = 64;
    localparam int AS_IMMW  = 16;
    localparam int AS_HISH  = 16;
    localparam int AS_CONDW = 4;

    typedef enum logic [2:0] {
        AS_ADD      = 3'd0,
        AS_SUBFROM  = 3'd1,
        AS_ADDEXT   = 3'd2,
        AS_ADDM1    = 3'd3,
        AS_ADDZ     = 3'd4,
        AS_ADDIMM   = 3'd5,
        AS_ADDIMMHI = 3'd6,
        AS_SUBIMM   = 3'd7
    } as_op_e;

    typedef struct packed {
        logic [AS_XLEN-1:0] x;
        logic [AS_XLEN-1:0] y;
        logic               cin;
    } as_operands_t;

    typedef struct packed {
        logic [AS_XLEN-1:0] sum;
        logic               c_half;
        logic               c_full;
    } as_sum_t;

    function automatic logic [AS_XLEN-1:0] as_sext(input logic [AS_IMMW-1:0] imm);
        return {{(AS_XLEN-AS_IMMW){imm[AS_IMMW-1]}}, imm};
    endfunction

    function automatic logic as_op_writes_carry(input as_op_e op);
        return (op == AS_ADDEXT) || (op == AS_ADDM1) ||
               (op == AS_ADDZ)   || (op == AS_SUBIMM);
    endfunction

    function automatic logic as_op_uses_r0_rule(input as_op_e op);
        return (op == AS_ADDIMM) || (op == AS_ADDIMMHI);
    endfunction

endpackage

// File: rtl/int_addsub_opsel.sv
module int_addsub_opsel
    import int_addsub_pkg::*;
(
    input  as_op_e              op,
    input  logic [AS_XLEN-1:0]  a,
    input  logic [AS_XLEN-1:0]  b,
    input  logic [AS_IMMW-1:0]  imm,
    input  logic                ra_is_r0,
    input  logic                ca,
    output as_operands_t        opnd
);
    logic [AS_XLEN-1:0] a_eff;
    logic [AS_XLEN-1:0] imm_lo;
    logic [AS_XLEN-1:0] imm_hi;

    always_comb begin
        a_eff  = (as_op_uses_r0_rule(op) && ra_is_r0) ? '0 : a;
        imm_lo = as_sext(imm);
        imm_hi = imm_lo << AS_HISH;
    end

    always_comb begin
        opnd = '{x: a_eff, y: b, cin: 1'b0};
        unique case (op)
            AS_ADD:      opnd = '{x: a,     y: b,      cin: 1'b0};
            AS_SUBFROM:  opnd = '{x: ~a,    y: b,      cin: 1'b1};
            AS_ADDEXT:   opnd = '{x: a,     y: b,      cin: ca};
            AS_ADDM1:    opnd = '{x: a,     y: '1,     cin: ca};
            AS_ADDZ:     opnd = '{x: a,     y: '0,     cin: ca};
            AS_ADDIMM:   opnd = '{x: a_eff, y: imm_lo, cin: 1'b0};
            AS_ADDIMMHI: opnd = '{x: a_eff, y: imm_hi, cin: 1'b0};
            AS_SUBIMM:   opnd = '{x: ~a,    y: imm_lo, cin: 1'b1};
            default:     opnd = '{x: a,     y: b,      cin: 1'b0};
        endcase
    end
endmodule

// File: rtl/int_addsub_adder.sv
module int_addsub_adder #(
    parameter int W = 64
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         c_half,
    output logic         c_full
);
    localparam int H  = W / 2;
    localparam int HU = W - H;

    logic [H:0]  lo;
    logic [HU:0] hi;

    always_comb begin
        lo = {1'b0, x[H-1:0]} + {1'b0, y[H-1:0]} + {{H{1'b0}}, cin};
        hi = {1'b0, x[W-1:H]} + {1'b0, y[W-1:H]} + {{HU{1'b0}}, lo[H]};
        sum    = {hi[HU-1:0], lo[H-1:0]};
        c_half = lo[H];
        c_full = hi[HU];
    end
endmodule

// File: rtl/int_addsub_cond.sv
module int_addsub_cond #(
    parameter int W = 64
) (
    input  logic [W-1:0] res,
    input  logic         so,
    output logic [3:0]   cond
);
    logic is_neg;
    logic is_zero;

    always_comb begin
        is_neg  = res[W-1];
        is_zero = (res == '0);
        cond    = {is_neg, !is_neg && !is_zero, is_zero, so};
    end
endmodule

// File: rtl/int_addsub.sv
module int_addsub
    import int_addsub_pkg::*;
(
    input  logic [63:0] a_i,
    input  logic [63:0] b_i,
    input  logic [15:0] imm_i,
    input  logic [2:0]  op_i,
    input  logic        ra_is_r0_i,
    input  logic        ca_i,
    input  logic        so_i,
    input  logic        rec_i,
    output logic [63:0] res_o,
    output logic [1:0]  carry_o,
    output logic        carry_we_o,
    output logic [3:0]  cond_o,
    output logic        cond_we_o
);
    as_op_e       op;
    as_operands_t opnd;
    as_sum_t      s;

    assign op = as_op_e'(op_i);

    int_addsub_opsel u_opsel (
        .op       (op),
        .a        (a_i),
        .b        (b_i),
        .imm      (imm_i),
        .ra_is_r0 (ra_is_r0_i),
        .ca       (ca_i),
        .opnd     (opnd)
    );

    int_addsub_adder #(.W(AS_XLEN)) u_adder (
        .x      (opnd.x),
        .y      (opnd.y),
        .cin    (opnd.cin),
        .sum    (s.sum),
        .c_half (s.c_half),
        .c_full (s.c_full)
    );

    int_addsub_cond #(.W(AS_XLEN)) u_cond (
        .res  (s.sum),
        .so   (so_i),
        .cond (cond_o)
    );

    assign res_o      = s.sum;
    assign carry_o    = {s.c_half, s.c_full};
    assign carry_we_o = as_op_writes_carry(op);
    assign cond_we_o  = rec_i;
endmodule

// File: rtl/int_addsub_check.sv
module int_addsub_check (
    input logic [63:0] a_i,
    input logic [63:0] b_i,
    input logic [2:0]  op_i,
    input logic        ca_i,
    input logic        so_i,
    input logic        rec_i,
    input logic [63:0] res_o,
    input logic        carry_we_o,
    input logic [3:0]  cond_o,
    input logic        cond_we_o
);
    always_comb begin
        if (op_i == 3'd0)
            p_add_sum_r1: assert (res_o == a_i + b_i);
        if (op_i == 3'd2)
            p_ext_sum_r3: assert (res_o == a_i + b_i + {63'd0, ca_i});
        p_carry_we_r8: assert (carry_we_o ==
            (op_i == 3'd2 || op_i == 3'd3 || op_i == 3'd4 || op_i == 3'd7));
        p_sign_onehot_r9: assert ($countones(cond_o[3:1]) == 1);
        p_neg_bit_r9: assert (cond_o[3] == res_o[63]);
        p_zero_bit_r9: assert (cond_o[1] == (res_o == 64'd0));
        p_so_copy_r9: assert (cond_o[0] == so_i);
        p_cond_we_r10: assert (cond_we_o == rec_i);
    end
endmodule

bind int_addsub int_addsub_check u_check (
    .a_i        (a_i),
    .b_i        (b_i),
    .op_i       (op_i),
    .ca_i       (ca_i),
    .so_i       (so_i),
    .rec_i      (rec_i),
    .res_o      (res_o),
    .carry_we_o (carry_we_o),
    .cond_o     (cond_o),
    .cond_we_o  (cond_we_o)
);

// File: tb/int_addsub_test.sv
module int_addsub_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] a, b;
    logic [15:0] imm;
    logic [2:0]  op;
    logic        rz, ca, so, rec;
    logic [63:0] res;
    logic [1:0]  carry;
    logic        carry_we, cond_we;
    logic [3:0]  cond;

    int n_checks = 0;
    int n_fail   = 0;
    logic [63:0] lfsr = 64'h9e37_79b9_7f4a_7c15;

    always #4 clk = ~clk;

    int_addsub uut (
        .a_i(a), .b_i(b), .imm_i(imm), .op_i(op), .ra_is_r0_i(rz),
        .ca_i(ca), .so_i(so), .rec_i(rec), .res_o(res), .carry_o(carry),
        .carry_we_o(carry_we), .cond_o(cond), .cond_we_o(cond_we)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] o, input logic [63:0] ai, input logic [63:0] bi,
                         input logic [15:0] im, input logic r0, input logic c, input logic s,
                         input logic r);
        @(negedge clk);
        op = o; a = ai; b = bi; imm = im; rz = r0; ca = c; so = s; rec = r;
        #1;
    endtask

    function automatic logic [63:0] sx(input logic [15:0] v);
        return {{48{v[15]}}, v};
    endfunction

    // sum model: {carry32, carry64, result}
    function automatic logic [65:0] model(input logic [63:0] x, input logic [63:0] y, input logic c);
        logic [64:0] full;
        logic [32:0] low;
        full = {1'b0, x} + {1'b0, y} + {64'd0, c};
        low  = {1'b0, x[31:0]} + {1'b0, y[31:0]} + {32'd0, c};
        return {low[32], full[64], full[63:0]};
    endfunction

    function automatic logic [3:0] cmodel(input logic [63:0] r, input logic s);
        if (r[63])      return {4'b1000} | {3'b0, s};
        else if (r == 0) return {4'b0010} | {3'b0, s};
        else            return {4'b0100} | {3'b0, s};
    endfunction

    task automatic step_lfsr();
        lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
    endtask

    task automatic t_idle();
        apply(3'd0, 64'd0, 64'd0, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R1 idle res", res, 64'd0);
        check("R9 idle cond", {60'd0, cond}, 64'h2);
        check("R10 idle cond_we", {63'd0, cond_we}, 64'd0);
        check("R8 idle carry_we", {63'd0, carry_we}, 64'd0);
    endtask

    task automatic t_add();
        apply(3'd0, 64'hc523e996a8ff6215, 64'he1e5b9cc9864c4a8, 16'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R1 add res", res, 64'ha709a363416426bd);
        check("R9 add cond", {60'd0, cond}, 64'h8);
        check("R7 add carry", {62'd0, carry}, 64'h3);
        check("R10 add cond_we", {63'd0, cond_we}, 64'd1);
        apply(3'd0, 64'h2e08ae202742baf8, 64'h86c43ece9efe5baa, 16'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R1 add res2", res, 64'hb4cceceec64116a2);
        check("R11 add ca/rz ignored", res, 64'hb4cceceec64116a2);
    endtask

    task automatic t_subf();
        apply(3'd1, 64'h3d7f3f7ca24bac7b, 64'hf6b2ac5e13ee15c2, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R2 subf res", res, 64'hb9336ce171a26947);
        apply(3'd1, 64'h10, 64'h5, 16'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R2 subf neg", res, 64'hfffffffffffffff5);
        check("R9 subf cond", {60'd0, cond}, 64'h8);
        apply(3'd1, 64'h5, 64'h5, 16'd0, 1'b0, 1'b0, 1'b1, 1'b1);
        check("R2 subf zero", res, 64'd0);
        check("R9 zero with so", {60'd0, cond}, 64'h3);
        check("R7 subf equal carry", {62'd0, carry}, 64'h3);
    endtask

    task automatic t_adde();
        apply(3'd2, 64'hffffffffffffffff, 64'h0, 16'd0, 1'b0, 1'b1, 1'b0, 1'b1);
        check("R3 adde wrap", res, 64'd0);
        check("R7 adde carry", {62'd0, carry}, 64'h3);
        check("R8 adde carry_we", {63'd0, carry_we}, 64'd1);
        apply(3'd2, 64'h00000000_7fffffff, 64'h00000000_80000000, 16'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R3 adde low carry", res, 64'h00000001_00000000);
        check("R7 carry32 only", {62'd0, carry}, 64'h2);
    endtask

    task automatic t_minus_zero();
        apply(3'd3, 64'h7ffffffff, 64'h1234, 16'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R4 addm1 ca0", res, 64'h7fffffffe);
        check("R7 addm1 carry", {62'd0, carry}, 64'h3);
        check("R9 addm1 cond", {60'd0, cond}, 64'h4);
        apply(3'd3, 64'hffff80000, 64'h0, 16'd0, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R4 addm1 ca1", res, 64'hffff80000);
        check("R9 addm1 so", {60'd0, cond}, 64'h5);
        apply(3'd3, 64'h0, 64'h0, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R4 addm1 zero in", res, 64'hffffffffffffffff);
        check("R7 addm1 no carry", {62'd0, carry}, 64'h0);
        apply(3'd4, 64'h00ff00ff00ff0080, 64'hffff, 16'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R4 addz ca0", res, 64'h00ff00ff00ff0080);
        check("R8 addz carry_we", {63'd0, carry_we}, 64'd1);
        apply(3'd4, 64'hffffffffffffffff, 64'h0, 16'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R4 addz ca1 wrap", res, 64'd0);
        check("R7 addz carry", {62'd0, carry}, 64'h3);
    endtask

    task automatic t_imm();
        apply(3'd6, 64'h5, 64'h0, 16'h0001, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R5 addimmhi r0", res, 64'h10000);
        check("R8 addimmhi carry_we", {63'd0, carry_we}, 64'd0);
        apply(3'd6, 64'h5, 64'h0, 16'hffff, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R5 addimmhi neg", res, 64'hffffffffffff0000);
        apply(3'd6, 64'h5, 64'h0, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R5 addimmhi reg", res, 64'h10005);
        apply(3'd5, 64'h100, 64'h0, 16'hfffe, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R5 addimm neg", res, 64'hfe);
        apply(3'd5, 64'h100, 64'h0, 16'hfffe, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R5 addimm r0", res, 64'hfffffffffffffffe);
        apply(3'd7, 64'h1, 64'h0, 16'h0001, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R6 subimm eq", res, 64'd0);
        check("R11 subimm rz ignored", res, 64'd0);
        check("R7 subimm carry", {62'd0, carry}, 64'h3);
        check("R8 subimm carry_we", {63'd0, carry_we}, 64'd1);
        apply(3'd7, 64'h5, 64'h0, 16'hffff, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R6 subimm negimm", res, 64'hfffffffffffffffa);
    endtask

    task automatic t_sweep();
        for (int i = 0; i < 64; i++) begin
            logic [63:0] x, y, e_x, e_y, bb;
            logic        e_c;
            logic [65:0] m;
            logic [2:0]  o;
            logic [15:0] im;
            logic        r0, c, s, r;
            step_lfsr(); x = lfsr;
            step_lfsr(); bb = lfsr;
            o = 3'(i % 8); im = lfsr[47:32];
            r0 = lfsr[3]; c = lfsr[5]; s = lfsr[7]; r = lfsr[9];
            e_c = 1'b0; e_x = x; e_y = bb;
            case (o)
                3'd1: begin e_x = ~x; e_c = 1'b1; end
                3'd2: e_c = c;
                3'd3: begin e_y = '1; e_c = c; end
                3'd4: begin e_y = '0; e_c = c; end
                3'd5: begin e_x = r0 ? 64'd0 : x; e_y = sx(im); end
                3'd6: begin e_x = r0 ? 64'd0 : x; e_y = sx(im) << 16; end
                3'd7: begin e_x = ~x; e_y = sx(im); e_c = 1'b1; end
                default: ;
            endcase
            m = model(e_x, e_y, e_c);
            y = bb;
            apply(o, x, y, im, r0, c, s, r);
            check("R1 R2 R3 R4 R5 R6 sweep res", res, m[63:0]);
            check("R7 sweep carry", {62'd0, carry}, {62'd0, m[65], m[64]});
            check("R9 sweep cond", {60'd0, cond}, {60'd0, cmodel(m[63:0], s)});
            check("R8 sweep carry_we", {63'd0, carry_we},
                  {63'd0, (o == 3'd2 || o == 3'd3 || o == 3'd4 || o == 3'd7)});
            check("R10 sweep cond_we", {63'd0, cond_we}, {63'd0, r});
        end
    endtask

    initial begin
        a = '0; b = '0; imm = '0; op = '0; rz = 1'b0; ca = 1'b0; so = 1'b0; rec = 1'b0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        t_idle();
        t_add();
        t_subf();
        t_adde();
        t_minus_zero();
        t_imm();
        t_sweep();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule